// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Engine with Clock Suspend

This block models, at cycle level, the device-side column path of a four-bank, 16-bit-wide synchronous DRAM. It decodes a two-bit command bus. A READ or WRITE starts a fixed-length column burst, and an internal beat counter walks the columns in sequential order. The order wraps inside an aligned group of `BURST_LEN` columns. Read data leaves the block `CAS_LAT` edges after the command. Write data is taken on the command edge and on the edges that follow. The bidirectional data pin is split into `din`, `dout` and an output enable `dq_oe`. A small storage array per bank holds the data.

The block supports clock suspend. `cke` is registered on every rising edge. While a burst is active, a registered low value suppresses the next internal edge. On a suppressed edge the burst counter does not advance, inputs are not sampled and `dout`/`dq_oe` keep their values. No gated clock is used: the registered `cke` qualifies every state update. When no burst is active a low `cke` has no effect, so the controller never stalls an idle device.

Top module: `sdr_burst_core`

## Requirements
- R1: While `rst_n` is low and after it is released, `dq_oe` is 0, `dout` is 0 and no burst is active.
- R2: A READ (cmd 2'b01) accepted at edge t with no suspension drives `dq_oe` high with the four read beats in the cycles after edges t+2, t+3, t+4 and t+5 (CAS latency 2), and `dq_oe` stays low after edges t and t+1.
- R3: `dq_oe` is high only while a burst is active; after the last read beat it returns low with `dout` at 0.
- R4: Beat j of a burst of length 4 uses column {start[COL_W-1:2], (start[1:0]+j) mod 4} in the bank given with the command.
- R5: A WRITE (cmd 2'b10) stores `din` from its command edge at the start column and `din` from the next three effective edges at the following columns in R4 order.
- R6: If `cke` is sampled low at an edge while a burst is active, the next edge is suppressed. The beat counter and latency counter hold, and `dout` and `dq_oe` keep their values.
- R7: Write data and commands present at a suppressed edge are ignored and never written into the array.
- R8: Suspension lasts for as long as `cke` is sampled low. After `cke` is sampled high, operation resumes on the next edge. A burst with N suppressed edges delivers the same beat sequence as an unsuspended burst, only N cycles later.
- R9: `cke` sampled low while no burst is active has no effect: a command at the next edge is accepted with normal timing.
- R10: READ or WRITE commands issued while a burst is active are ignored. They neither disturb the running burst nor write the array.
- R11: Command code 2'b00 is NOP and the reserved code 2'b11 is treated as NOP. Neither starts a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, registered each edge; low suspends the next internal edge during a burst |
| cmd | input | 2 | Command: 00 NOP, 01 READ, 10 WRITE, 11 reserved (NOP) |
| bank | input | BANK_W | Bank select for the command |
| col | input | COL_W | Start column for the command |
| din | input | DATA_W | Write data from the data pin |
| dout | output | DATA_W | Read data toward the data pin |
| dq_oe | output | 1 | Data pin output enable, high while a read beat is driven |

## Verification
The bench builds the block with four banks, 16 columns per bank, 16-bit data, burst length 4 and CAS latency 2. That makes 64 words in total, so every bank and every start column can be written and read back. Each possible wrap of the column order within its four-column group is therefore covered. The short burst also makes it practical to place a suspension window at every edge of a read and of a write. Windows of one to three edges are used, and each resulting trace is compared with the unsuspended trace shifted by the window length.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    // Command bus encoding seen on cmd
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } sdr_cmd_e;

    // Phase of the column engine
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LAT   = 2'd1,
        PH_RDATA = 2'd2,
        PH_WDATA = 2'd3
    } sdr_phase_e;

endpackage

// File: rtl/sdr_clk_suspend.sv
module sdr_clk_suspend (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic busy,
    output logic int_en
);

    logic cke_d;
    logic cke_q;

    always_comb begin
        cke_d = cke;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
        end else begin
            cke_q <= cke_d;
        end
    end

    // An edge is suppressed only when the previous edge saw cke low
    // and a column burst is under way.
    assign int_en = cke_q | ~busy;

endmodule

// File: rtl/sdr_bank_array.sv
module sdr_bank_array #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);

    localparam int BANKS = 1 << BANK_W;
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] bank_rd [BANKS];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic [DATA_W-1:0] cells [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && (wr_bank == BANK_W'(b))) begin
                    cells[wr_col] <= wr_data;
                end
            end

            assign bank_rd[b] = cells[rd_col];
        end
    endgenerate

    assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
    import sdr_burst_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_en,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data,
    output logic [BANK_W-1:0] rd_bank,
    output logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] dout,
    output logic              dq_oe,
    output logic              busy
);

    localparam int BL_W     = $clog2(BURST_LEN);
    localparam int BEAT_W   = BL_W + 1;
    localparam int LAT_W    = $clog2(CAS_LAT + 1);
    localparam int LAT_LOAD = CAS_LAT - 1;

    typedef struct packed {
        sdr_phase_e        phase;
        logic [LAT_W-1:0]  lat;
        logic [BEAT_W-1:0] beat;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [DATA_W-1:0] data;
        logic              oe;
    } eng_t;

    eng_t       eng_d;
    eng_t       eng_q;
    sdr_cmd_e   cmd_e;

    assign cmd_e = sdr_cmd_e'(cmd);

    // Sequential order that wraps inside the aligned burst group
    function automatic logic [COL_W-1:0] beat_col(
        input logic [COL_W-1:0]  s,
        input logic [BEAT_W-1:0] b
    );
        logic [BL_W-1:0] lo;
        lo = s[BL_W-1:0] + b[BL_W-1:0];
        return {s[COL_W-1:BL_W], lo};
    endfunction

    always_comb begin
        eng_d   = eng_q;
        wr_en   = 1'b0;
        wr_bank = eng_q.bank;
        wr_col  = beat_col(eng_q.start, eng_q.beat);
        wr_data = din;
        rd_bank = eng_q.bank;
        rd_col  = beat_col(eng_q.start, eng_q.beat);

        if (int_en) begin
            unique case (eng_q.phase)
                PH_IDLE: begin
                    if (cmd_e == CMD_READ) begin
                        eng_d.phase = PH_LAT;
                        eng_d.lat   = LAT_W'(LAT_LOAD);
                        eng_d.beat  = '0;
                        eng_d.bank  = bank_in;
                        eng_d.start = col_in;
                    end else if (cmd_e == CMD_WRITE) begin
                        wr_en       = 1'b1;
                        wr_bank     = bank_in;
                        wr_col      = col_in;
                        eng_d.phase = PH_WDATA;
                        eng_d.beat  = BEAT_W'(1);
                        eng_d.bank  = bank_in;
                        eng_d.start = col_in;
                    end
                end
                PH_LAT: begin
                    if (eng_q.lat == '0) begin
                        eng_d.data  = rd_data;
                        eng_d.oe    = 1'b1;
                        eng_d.beat  = BEAT_W'(1);
                        eng_d.phase = PH_RDATA;
                    end else begin
                        eng_d.lat = eng_q.lat - LAT_W'(1);
                    end
                end
                PH_RDATA: begin
                    if (eng_q.beat == BEAT_W'(BURST_LEN)) begin
                        eng_d.data  = '0;
                        eng_d.oe    = 1'b0;
                        eng_d.phase = PH_IDLE;
                    end else begin
                        eng_d.data = rd_data;
                        eng_d.beat = eng_q.beat + BEAT_W'(1);
                    end
                end
                PH_WDATA: begin
                    wr_en      = 1'b1;
                    eng_d.beat = eng_q.beat + BEAT_W'(1);
                    if (eng_q.beat == BEAT_W'(BURST_LEN - 1)) begin
                        eng_d.phase = PH_IDLE;
                    end
                end
                default: eng_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign dout  = eng_q.data;
    assign dq_oe = eng_q.oe;
    assign busy  = (eng_q.phase != PH_IDLE);

endmodule

// File: rtl/sdr_burst_core.sv
module sdr_burst_core #(
    parameter int BANK_W    = 2,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dq_oe
);

    logic              busy;
    logic              int_en;
    logic              wr_en;
    logic [BANK_W-1:0] wr_bank;
    logic [COL_W-1:0]  wr_col;
    logic [DATA_W-1:0] wr_data;
    logic [BANK_W-1:0] rd_bank;
    logic [COL_W-1:0]  rd_col;
    logic [DATA_W-1:0] rd_data;

    sdr_clk_suspend u_suspend (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .busy   (busy),
        .int_en (int_en)
    );

    sdr_burst_ctrl #(
        .BANK_W    (BANK_W),
        .COL_W     (COL_W),
        .DATA_W    (DATA_W),
        .BURST_LEN (BURST_LEN),
        .CAS_LAT   (CAS_LAT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_en  (int_en),
        .cmd     (cmd),
        .bank_in (bank),
        .col_in  (col),
        .din     (din),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_col  (wr_col),
        .wr_data (wr_data),
        .rd_bank (rd_bank),
        .rd_col  (rd_col),
        .dout    (dout),
        .dq_oe   (dq_oe),
        .busy    (busy)
    );

    sdr_bank_array #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_col  (wr_col),
        .wr_data (wr_data),
        .rd_bank (rd_bank),
        .rd_col  (rd_col),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/sdr_burst_core_chk.sv
module sdr_burst_core_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic [1:0]        cmd,
    input logic [DATA_W-1:0] dout,
    input logic              dq_oe,
    input logic              busy,
    input logic              int_en
);

    // A suppressed edge leaves the pin side untouched
    assert_frozen_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> ($stable(dout) && $stable(dq_oe)));

    // Suppression needs a burst in flight and cke low at the previous edge
    assert_suspend_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> (busy && !$past(cke)));

    // Output enable only inside a burst
    assert_oe_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> busy);

    // Idle READ is taken whatever cke did before
    assert_idle_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd == 2'b01) |=> busy);

    // No data in the cycle right after the READ edge
    assert_cas_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd == 2'b01) |=> !dq_oe);

    // Reserved code never starts a burst
    assert_rsvd_nop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cmd == 2'b11 || cmd == 2'b00)) |=> !busy);

endmodule

bind sdr_burst_core sdr_burst_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .cmd    (cmd),
    .dout   (dout),
    .dq_oe  (dq_oe),
    .busy   (busy),
    .int_en (int_en)
);

// File: tb/sdr_burst_core_tb.sv
module sdr_burst_core_tb;

    localparam int BANK_W = 2;
    localparam int BANKS  = 1 << BANK_W;
    localparam int COL_W  = 4;
    localparam int NCOL   = 1 << COL_W;
    localparam int DW     = 16;
    localparam int BL     = 4;
    localparam int CL     = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cke;
    logic [1:0]        cmd;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [DW-1:0]     din;
    logic [DW-1:0]     dout;
    logic              dq_oe;

    logic [DW-1:0] model [BANKS][NCOL];
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    sdr_burst_core #(
        .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DW), .BURST_LEN(BL), .CAS_LAT(CL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank),
        .col(col), .din(din), .dout(dout), .dq_oe(dq_oe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [COL_W-1:0] col_at(logic [COL_W-1:0] s, int j);
        logic [1:0] lo;
        lo = s[1:0] + 2'(j);
        return {s[COL_W-1:2], lo};
    endfunction

    // Read burst; cke low sampled at edges s..s+n-1 suppresses s+1..s+n
    task automatic rd_burst(int b, int c, int s, int n, bit intrude, string tag);
        cmd  = 2'b01;
        bank = BANK_W'(b);
        col  = COL_W'(c);
        cke  = (n > 0 && s == 0) ? 1'b0 : 1'b1;
        for (int k = 0; k <= CL + BL + n; k++) begin
            int  lg;
            bit  e_oe;
            int  e_d;
            tick();
            cmd = 2'b00;
            cke = (n > 0 && k + 1 >= s && k + 1 <= s + n - 1) ? 1'b0 : 1'b1;
            if (intrude && (k == 1 || k == 3)) begin
                cmd  = (k == 1) ? 2'b10 : 2'b01;
                bank = '0;
                col  = COL_W'(12);
                din  = 16'hBAD0;
            end
            if (n == 0 || k <= s)   lg = k;
            else if (k <= s + n)    lg = s;
            else                    lg = k - n;
            e_oe = (lg >= CL && lg <= CL + BL - 1);
            e_d  = e_oe ? int'(model[b][col_at(COL_W'(c), lg - CL)]) : 0;
            check(tag, int'(dq_oe), int'(e_oe));
            check(tag, int'(dout), e_d);
        end
        cke = 1'b1;
    endtask

    // Write burst; suppressed edges get junk din and a READ command
    task automatic wr_burst(int b, int c, int s, int n, logic [DW-1:0] base);
        int beat = 1;
        cmd  = 2'b10;
        bank = BANK_W'(b);
        col  = COL_W'(c);
        din  = base;
        cke  = (n > 0 && s == 0) ? 1'b0 : 1'b1;
        model[b][col_at(COL_W'(c), 0)] = base;
        for (int k = 1; k <= BL - 1 + n; k++) begin
            bit susp;
            tick();
            susp = (n > 0 && k >= s + 1 && k <= s + n);
            cmd  = 2'b01;
            cke  = (n > 0 && k >= s && k <= s + n - 1) ? 1'b0 : 1'b1;
            if (susp) begin
                din = 16'hDEAD;
            end else begin
                din = base + DW'(beat * 16'h0011);
                model[b][col_at(COL_W'(c), beat)] = din;
                beat++;
            end
        end
        tick();
        cmd = 2'b00;
        cke = 1'b1;
    endtask

    initial begin
        for (int b = 0; b < BANKS; b++)
            for (int c = 0; c < NCOL; c++)
                model[b][c] = '0;
        rst_n = 1'b0;
        cke   = 1'b1;
        cmd   = 2'b00;
        bank  = '0;
        col   = '0;
        din   = '0;
        repeat (3) tick();
        check("R1", int'(dq_oe), 0);
        check("R1", int'(dout), 0);
        rst_n = 1'b1;
        tick();
        check("R1", int'(dq_oe), 0);

        // R5: fill every bank through aligned write bursts
        for (int b = 0; b < BANKS; b++)
            for (int g = 0; g < NCOL / BL; g++)
                wr_burst(b, g * BL, 0, 0, DW'((b << 12) | (g << 8) | 16'h0005));

        // R2, R4, R5: every start column of every bank
        for (int b = 0; b < BANKS; b++)
            for (int c = 0; c < NCOL; c++)
                rd_burst(b, c, 0, 0, 1'b0,
                         (c % BL != 0) ? "R4" : ((b == 0) ? "R2" : "R5"));

        // R3: enable stays low once the burst has ended
        tick();
        check("R3", int'(dq_oe), 0);
        check("R3", int'(dout), 0);

        // R6, R8: suspension window at every edge of a read, lengths 1..3
        for (int s = 0; s <= CL + BL - 1; s++)
            for (int n = 1; n <= 3; n++)
                rd_burst(1, 6, s, n, 1'b0, (n == 1) ? "R6" : "R8");

        // R7: suspended write edges must not store junk
        for (int s = 0; s <= BL - 2; s++)
            for (int n = 1; n <= 2; n++) begin
                wr_burst(2, 8 + s, s, n, DW'(16'h7000 + s * 16'h0100 + n * 16'h0020));
                rd_burst(2, 8, 0, 0, 1'b0, "R7");
            end

        // R9: cke low while idle, then a READ with normal timing
        cke = 1'b0;
        repeat (3) tick();
        rd_burst(3, 5, 0, 0, 1'b0, "R9");

        // R10: commands during a burst are ignored
        rd_burst(3, 2, 0, 0, 1'b1, "R10");
        rd_burst(0, 12, 0, 0, 1'b0, "R10");

        // R11: reserved code acts as NOP
        cmd  = 2'b11;
        bank = 2'd1;
        col  = 4'd3;
        for (int k = 0; k < CL + BL + 1; k++) begin
            tick();
            cmd = 2'b00;
            check("R11", int'(dq_oe), 0);
        end
        rd_burst(1, 3, 0, 0, 1'b0, "R11");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule